// File: doc/BRIEF.md
# Reference Frequency Out-of-Range Monitor

This block watches one timing reference and reports whether its frequency sits within a fixed parts-per-million window around a selected nominal rate. The reference may nominally run at 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. A 2-bit select input picks the rate. A free-running 20 MHz local clock provides the timebase, and the monitor assumes that clock is exact.

Inside the reference domain, a counter counts falling edges of the reference. Each time the count reaches the number of edges in one nominal second, a gate flag toggles. The toggle crosses into the timebase domain through a synchronizer. There, the monitor counts timebase cycles between successive toggles.

When each gate period closes, the cycle count is compared with the nominal cycle count. The flag is raised if the count differs by more than 240 cycles, which is 12 ppm of 20,000,000. Otherwise the flag is cleared. The flag holds its value until the next period closes. The edge counts, the nominal cycle count and the tolerance are parameters, so the measurement can be scaled down.

Top module: `ref_oor_monitor`

## Requirements
- R1: The select code picks the number of reference falling edges per gate period: 00 → EDGES_SEL0 (8000), 01 → EDGES_SEL1 (1544000), 10 → EDGES_SEL2 (2048000), 11 → EDGES_SEL3 (19440000). A reference running at exactly that nominal rate leaves the flag low.
- R2: Only falling edges of the reference are counted, so the duty cycle of the reference has no effect on the result.
- R3: When a gate period closes with a cycle count greater than NOMINAL_CYC + TOL_CYC, the flag becomes 1.
- R4: When a gate period closes with a cycle count less than NOMINAL_CYC − TOL_CYC, the flag becomes 1.
- R5: When a gate period closes with a cycle count within ±TOL_CYC of NOMINAL_CYC, the flag becomes 0.
- R6: The flag changes only on the timebase cycle that follows the close of a gate period, or when the select changes.
- R7: Reset drives the flag to 0. The first gate period after reset is discarded, so the flag stays 0 until a full period has been measured.
- R8: A change of the select clears the flag on the next timebase edge. The first gate period after the change is discarded, so the flag stays 0 until a full period has been measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_in | input | 1 | Reference under test; only its falling edges are used |
| rate_sel | input | 2 | Nominal rate select (encoding in R1) |
| out_of_range | output | 1 | Registered flag in the timebase domain; 1 means the reference is outside the tolerance window |

## Verification
The embedded assertions check four things on every cycle of their clock:
- the flag holds between gate closes;
- a select change clears the flag;
- the flag stays low while no full period has been measured;
- the reference-domain counter restarts and toggles the gate once it reaches the selected edge count.

The ppm window itself, the independence from duty cycle and the correct edge count for each select code can only be shown by the bench's scenarios. In those scenarios the reference is driven at chosen periods, just inside and just outside the tolerance on both sides. The flag is then compared every clock against the value the requirements predict.

// File: rtl/ref_oor_monitor.sv
module ref_oor_monitor #(
  parameter int unsigned EDGES_SEL0  = 8000,
  parameter int unsigned EDGES_SEL1  = 1544000,
  parameter int unsigned EDGES_SEL2  = 2048000,
  parameter int unsigned EDGES_SEL3  = 19440000,
  parameter int unsigned NOMINAL_CYC = 20000000,
  parameter int unsigned TOL_CYC     = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [1:0] rate_sel,
  output logic       out_of_range
);

  localparam int unsigned MAX_A     = (EDGES_SEL0 > EDGES_SEL1) ? EDGES_SEL0 : EDGES_SEL1;
  localparam int unsigned MAX_B     = (EDGES_SEL2 > EDGES_SEL3) ? EDGES_SEL2 : EDGES_SEL3;
  localparam int unsigned MAX_EDGES = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned REF_W     = $clog2(MAX_EDGES + 1);
  localparam int unsigned CYC_W     = $clog2(2 * NOMINAL_CYC + 1);
  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [CYC_W-1:0] NOM     = CYC_W'(NOMINAL_CYC);
  localparam logic [CYC_W-1:0] TOL     = CYC_W'(TOL_CYC);

  // Reference domain: falling-edge counter and gate toggle
  logic [1:0]       sel_m, sel_r;
  logic [REF_W-1:0] ref_cnt, lim_m1;
  logic             gate_tog;

  always_comb begin
    unique case (sel_r)
      2'd0:    lim_m1 = REF_W'(EDGES_SEL0 - 1);
      2'd1:    lim_m1 = REF_W'(EDGES_SEL1 - 1);
      2'd2:    lim_m1 = REF_W'(EDGES_SEL2 - 1);
      default: lim_m1 = REF_W'(EDGES_SEL3 - 1);
    endcase
  end

  wire ref_wrap = (ref_cnt >= lim_m1);

  always_ff @(negedge ref_in or negedge rst_n) begin
    if (!rst_n) begin
      sel_m    <= 2'd0;
      sel_r    <= 2'd0;
      ref_cnt  <= '0;
      gate_tog <= 1'b0;
    end else begin
      sel_m <= rate_sel;
      sel_r <= sel_m;
      if (ref_wrap) begin
        ref_cnt  <= '0;
        gate_tog <= ~gate_tog;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  AST_REF_WRAP: assert property (@(negedge ref_in) disable iff (!rst_n)
    ref_wrap |=> (ref_cnt == '0) && (gate_tog != $past(gate_tog))); // R1

  // Timebase domain: synchronizer, period counter, window compare
  logic [2:0]       tog_sync;
  logic [1:0]       sel_q;
  logic             armed;
  logic [CYC_W-1:0] cyc_cnt;

  wire             gate_edge  = tog_sync[1] ^ tog_sync[2];
  wire             sel_change = (rate_sel != sel_q);
  wire [CYC_W-1:0] dev        = (cyc_cnt > NOM) ? (cyc_cnt - NOM) : (NOM - cyc_cnt);
  wire             off_win    = (dev > TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_sync     <= 3'b000;
      sel_q        <= 2'd0;
      armed        <= 1'b0;
      cyc_cnt      <= '0;
      out_of_range <= 1'b0;
    end else begin
      tog_sync <= {tog_sync[1:0], gate_tog};
      sel_q    <= rate_sel;
      if (gate_edge)
        cyc_cnt <= CYC_W'(1);
      else if (cyc_cnt != CYC_MAX)
        cyc_cnt <= cyc_cnt + 1'b1;
      if (sel_change) begin
        armed        <= 1'b0;
        out_of_range <= 1'b0;
      end else if (gate_edge) begin
        armed <= 1'b1;
        if (armed)
          out_of_range <= off_win;
      end
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_edge && !sel_change) |=> $stable(out_of_range)); // R6

  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> !out_of_range && !armed); // R8

  AST_UNARMED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_of_range); // R7

endmodule

// File: tb/tb_ref_oor_monitor.sv
`timescale 1ns/1ps
module tb_ref_oor_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b1;
  logic [1:0] rate_sel = 2'd3;
  logic       out_of_range;

  real hi_ns = 50.7;
  real lo_ns = 50.7;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit    exp_known = 1'b0;
  bit    exp_val = 1'b0;
  string cur_req = "R7";

  ref_oor_monitor #(
    .EDGES_SEL0(8), .EDGES_SEL1(40), .EDGES_SEL2(50), .EDGES_SEL3(100),
    .NOMINAL_CYC(1000), .TOL_CYC(12)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .rate_sel(rate_sel), .out_of_range(out_of_range)
  );

  always #5 clk = ~clk;

  always begin
    ref_in = 1'b1;
    #(hi_ns);
    ref_in = 1'b0;
    #(lo_ns);
  end

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: out_of_range=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: expected flag value per phase, compared every clock
  always @(posedge clk) begin
    #2;
    if (exp_known) check(cur_req, out_of_range, exp_val);
  end

  task automatic scen(input logic [1:0] s, input real period, input real duty,
                      input bit exp, input string req);
    bit changed;
    @(negedge clk);
    exp_known = 1'b0;
    changed = (s != rate_sel);
    rate_sel = s;
    hi_ns = period * duty;
    lo_ns = period - hi_ns;
    if (changed) begin
      @(negedge clk);
      cur_req = "R8";
      exp_val = 1'b0;
      exp_known = 1'b1;
      repeat (899) @(negedge clk);
      exp_known = 1'b0;
      repeat (1300) @(negedge clk);
    end else begin
      repeat (2200) @(negedge clk);
    end
    cur_req = req;
    exp_val = exp;
    exp_known = 1'b1;
    repeat (2000) @(negedge clk);
    exp_known = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R7", out_of_range, 1'b0);
    rst_n = 1'b1;
    cur_req = "R7";
    exp_val = 1'b0;
    exp_known = 1'b1;
    repeat (900) @(negedge clk);
    exp_known = 1'b0;
    repeat (1300) @(negedge clk);
    cur_req = "R3";
    exp_val = 1'b1;
    exp_known = 1'b1;
    repeat (1500) @(negedge clk);
    exp_known = 1'b0;

    scen(2'd3, 100.0, 0.5, 1'b0, "R1");
    scen(2'd3, 101.1, 0.5, 1'b0, "R5");
    scen(2'd3, 98.6,  0.5, 1'b1, "R4");
    scen(2'd3, 98.9,  0.5, 1'b0, "R5");
    scen(2'd3, 98.6,  0.5, 1'b1, "R4");
    scen(2'd2, 204.0, 0.5, 1'b1, "R3");
    scen(2'd2, 200.0, 0.5, 1'b0, "R1");
    scen(2'd1, 250.0, 0.5, 1'b0, "R1");
    scen(2'd1, 253.6, 0.5, 1'b1, "R3");
    scen(2'd0, 1250.0, 0.5, 1'b0, "R1");
    scen(2'd0, 1232.0, 0.5, 1'b1, "R4");
    scen(2'd3, 100.0, 0.25, 1'b0, "R2");
    scen(2'd3, 101.4, 0.25, 1'b1, "R2");
    scen(2'd3, 98.6,  0.8,  1'b1, "R2");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", out_of_range, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", out_of_range, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule